// File: doc/BRIEF.md
# Receive Byte Queue with Status-Qualified Bus Read

This block sits between a byte-level serial receiver and an asynchronous processor bus. Bytes from the receiver are held in a small synchronous FIFO. The processor collects each byte with a single bus read. That one read word carries the oldest byte, a flag saying the byte is valid, and a sticky overflow flag, so software never needs a separate status access.

The read strobe and the access enable arrive asynchronously and are synchronized into the system clock. When the synchronized enable rises, the block takes a snapshot of the queue head and its status. The read word always returns that snapshot. The byte is removed when the synchronized read strobe rises, and only if the snapshot said a byte was present. A byte that lands in an empty queue partway through a read is therefore neither lost nor returned twice. The bus-ready output is held off until the snapshot exists. The block also re-registers the raw serial line through two flops for the receiver.

Top module: `rxq_bus_port`

## Requirements
- R1: Bytes written with `rx_wr_i` high are returned by later reads in arrival order, and up to DEPTH (default 16) bytes are held.
- R2: The read word places the byte in bits [7:0], the present flag in bit 8 and the overflow flag in bit 9, with bits [15:10] at zero. A read made while the queue is empty returns 0x000 in bits [9:0] unless overflow is set.
- R3: `bus_rdata_o` is all zero whenever the synchronized read strobe is high.
- R4: Each access removes at most one byte, and only when the snapshot taken at the access start reported a byte present.
- R5: A read made while the queue is empty leaves the queue contents and the byte order unchanged.
- R6: A byte pushed into an empty queue after the access has started is kept and returned by the next read.
- R7: `bus_ready_o` is low until the snapshot is taken, which is three system clocks after the raw enable rises. It then stays high, and it returns low within three clocks of the enable falling.
- R8: A push into a full queue discards the byte and sets the sticky overflow flag, which shows in bit 9 of the next snapshot. An access that removes a byte while reporting overflow clears the flag.
- R9: A push and a removal in the same clock both take effect with no byte lost or duplicated.
- R10: `line_sync_o` follows `serial_in` after exactly two system clock edges and resets to 1.
- R11: During reset the read word is zero, ready is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| serial_in | input | 1 | Raw asynchronous serial line |
| line_sync_o | output | 1 | Serial line after two-flop re-registering |
| rx_wr_i | input | 1 | Receiver byte-complete strobe, one clock wide |
| rx_byte_i | input | 8 | Received byte |
| bus_en_i | input | 1 | Asynchronous access enable, active high |
| bus_rd_n_i | input | 1 | Asynchronous read strobe, active low |
| bus_rdata_o | output | 16 | Read word: byte, present flag, overflow flag |
| bus_ready_o | output | 1 | Access may complete |

## Verification
A vector table mixes pushes with reads, including reads on an empty queue, so order, word format and empty-read behaviour are checked together. A fill past capacity separates a correct discard-and-flag from silent overwrite, and shows that the flag clears once reported. The race pattern pushes a byte during an empty read, which separates a snapshot-qualified removal from a blind one. A burst of pushes around the removal edge catches loss or duplication on a simultaneous push and removal.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int PRESENT_B = 8;
    localparam int OVF_B     = 9;

    typedef struct packed {
        logic              en_prev;
        logic              rd_prev;
        logic              armed;
        logic              ready;
        logic [BYTE_W-1:0] snap_byte;
        logic              snap_present;
        logic              snap_ovf;
        logic              ovf_sticky;
    } acc_state_t;
endpackage

// File: rtl/rxq_sync2.sv
module rxq_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;
    logic [W-1:0] s1_d, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          ovf_set
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic full, accept;

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        accept  = push && (!full || pop);
        ovf_set = push && full && !pop;
        st_d    = st_q;
        if (accept) st_d.wp = st_q.wp + AW'(1);
        if (pop)    st_d.rp = st_q.rp + AW'(1);
        if (accept && !pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (pop && !accept) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[st_q.wp] <= push_data;
    end

    assign head = mem_q[st_q.rp];

    // R4: removal never happens on an empty queue
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
    // R9: push and removal together keep occupancy
    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(st_q.cnt));
    // R8: a push into a full queue leaves it full, nothing overwritten
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CW'(DEPTH)) |=> (st_q.cnt == CW'(DEPTH) && $stable(st_q.wp)));
endmodule

// File: rtl/rxq_access.sv
module rxq_access
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              rd_s,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    input  logic              ovf_set,
    output logic              pop,
    output logic [WORD_W-1:0] word,
    output logic              ready
);
    acc_state_t st_q, st_d;
    logic en_rise, rd_rise;

    always_comb begin
        st_d    = st_q;
        en_rise = en_s && !st_q.en_prev;
        rd_rise = rd_s && !st_q.rd_prev;
        pop     = rd_rise && st_q.armed && st_q.snap_present;

        st_d.en_prev = en_s;
        st_d.rd_prev = rd_s;

        if (en_rise) begin
            st_d.snap_byte    = fifo_empty ? '0 : fifo_head;
            st_d.snap_present = !fifo_empty;
            st_d.snap_ovf     = st_q.ovf_sticky;
            st_d.armed        = 1'b1;
            st_d.ready        = 1'b1;
        end
        if (pop) st_d.armed = 1'b0;
        if (!en_s) begin
            st_d.armed = 1'b0;
            st_d.ready = 1'b0;
        end

        if (pop && st_q.snap_ovf) st_d.ovf_sticky = 1'b0;
        if (ovf_set)              st_d.ovf_sticky = 1'b1;

        word = '0;
        if (!rd_s) begin
            word[BYTE_W-1:0] = st_q.snap_byte;
            word[PRESENT_B]  = st_q.snap_present;
            word[OVF_B]      = st_q.snap_ovf;
        end
        ready = st_q.ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rd_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a removal only follows a snapshot that reported a byte
    p_pop_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.snap_present);
    // R4: never two removals on back-to-back clocks
    p_single_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);
    // R7: ready only while the synchronized enable was high
    p_ready_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(en_s));
endmodule

// File: rtl/rxq_bus_port.sv
module rxq_bus_port
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_in,
    output logic              line_sync_o,
    input  logic              rx_wr_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              bus_en_i,
    input  logic              bus_rd_n_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              bus_ready_o
);
    logic              en_s, rd_s;
    logic              pop, fifo_empty, ovf_set;
    logic [BYTE_W-1:0] fifo_head;

    rxq_sync2 #(.W(1), .RST_VAL(1'b1)) u_line_sync (
        .clk(clk), .rst_n(rst_n), .din(serial_in), .dout(line_sync_o));

    rxq_sync2 #(.W(1), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_en_i), .dout(en_s));

    rxq_sync2 #(.W(1), .RST_VAL(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_rd_n_i), .dout(rd_s));

    rxq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_wr_i), .push_data(rx_byte_i), .pop(pop),
        .head(fifo_head), .empty(fifo_empty), .ovf_set(ovf_set));

    rxq_access u_acc (
        .clk(clk), .rst_n(rst_n),
        .en_s(en_s), .rd_s(rd_s),
        .fifo_empty(fifo_empty), .fifo_head(fifo_head), .ovf_set(ovf_set),
        .pop(pop), .word(bus_rdata_o), .ready(bus_ready_o));

    // R3: no read data while the synchronized strobe is idle
    p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_s |-> (bus_rdata_o == '0));
endmodule

// File: tb/sim_rxq_bus_port.sv
module sim_rxq_bus_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serial_in = 1'b1;
    logic        line_sync_o;
    logic        rx_wr_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        bus_en_i = 1'b0;
    logic        bus_rd_n_i = 1'b1;
    logic [15:0] bus_rdata_o;
    logic        bus_ready_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rxq_bus_port u0 (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .line_sync_o(line_sync_o),
        .rx_wr_i(rx_wr_i), .rx_byte_i(rx_byte_i),
        .bus_en_i(bus_en_i), .bus_rd_n_i(bus_rd_n_i),
        .bus_rdata_o(bus_rdata_o), .bus_ready_o(bus_ready_o));

    // op in [17:16]: 1 = push byte [7:0], 2 = read and expect word [15:0]
    localparam logic [17:0] VEC [12] = '{
        {2'd1, 16'h0011}, {2'd1, 16'h0022}, {2'd1, 16'h0033},
        {2'd2, 16'h0111}, {2'd2, 16'h0122},
        {2'd1, 16'h0044},
        {2'd2, 16'h0133}, {2'd2, 16'h0144},
        {2'd2, 16'h0000},
        {2'd1, 16'h0055},
        {2'd2, 16'h0155}, {2'd2, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_wr_i = 1'b1; rx_byte_i = b;
        @(negedge clk);
        rx_wr_i = 1'b0;
    endtask

    task automatic do_read(output logic [15:0] w);
        @(negedge clk);
        bus_en_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd_n_i = 1'b0;
        repeat (5) @(negedge clk);
        w = bus_rdata_o;
        bus_rd_n_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_en_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 rdata", 32'(bus_rdata_o), 32'h0);
        check("R11 ready", 32'(bus_ready_o), 32'h0);
        check("R10 reset", 32'(line_sync_o), 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R5: table walk
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][17:16] == 2'd1) push(VEC[i][7:0]);
            else begin
                do_read(w);
                check("R1/R2/R5 table", 32'(w), 32'(VEC[i][15:0]));
            end
        end

        // R7 and R3: ready timing, data idle before strobe
        @(negedge clk);
        bus_en_i = 1'b1;
        @(negedge clk);
        check("R7 early", 32'(bus_ready_o), 32'h0);
        repeat (4) @(negedge clk);
        check("R7 held", 32'(bus_ready_o), 32'h1);
        check("R3 idle", 32'(bus_rdata_o), 32'h0);
        bus_en_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 drop", 32'(bus_ready_o), 32'h0);

        // R6: byte arrives during an empty read
        @(negedge clk);
        bus_en_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd_n_i = 1'b0;
        repeat (4) @(negedge clk);
        w = bus_rdata_o;
        check("R6 empty word", 32'(w), 32'h0);
        push(8'h5A);
        bus_rd_n_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_en_i = 1'b0;
        repeat (4) @(negedge clk);
        do_read(w);
        check("R6 kept", 32'(w), 32'h015A);
        do_read(w);
        check("R6 empty after", 32'(w), 32'h0);

        // R8: overflow
        for (int i = 0; i < 17; i++) push(8'(8'h80 + i));
        do_read(w);
        check("R8 flag", 32'(w), 32'h0380);
        for (int i = 1; i < 16; i++) begin
            do_read(w);
            check("R8 rest", 32'(w), 32'(16'h0100 | (8'h80 + i)));
        end
        do_read(w);
        check("R8 drop", 32'(w), 32'h0);

        // R9: push burst around the removal edge
        push(8'hA1);
        push(8'hA2);
        @(negedge clk);
        bus_en_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd_n_i = 1'b0;
        repeat (5) @(negedge clk);
        w = bus_rdata_o;
        check("R9 head", 32'(w), 32'h01A1);
        bus_rd_n_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            rx_wr_i = 1'b1; rx_byte_i = 8'(8'hB0 + k);
            @(negedge clk);
        end
        rx_wr_i = 1'b0;
        bus_en_i = 1'b0;
        repeat (4) @(negedge clk);
        do_read(w);
        check("R9 order", 32'(w), 32'h01A2);
        for (int k = 0; k < 6; k++) begin
            do_read(w);
            check("R9 burst", 32'(w), 32'(16'h0100 | (8'hB0 + k)));
        end
        do_read(w);
        check("R9 end", 32'(w), 32'h0);

        // R10: two-flop serial line
        @(negedge clk);
        serial_in = 1'b0;
        @(negedge clk);
        check("R10 one edge", 32'(line_sync_o), 32'h1);
        @(negedge clk);
        check("R10 two edges", 32'(line_sync_o), 32'h0);
        serial_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 back", 32'(line_sync_o), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule